// File: doc/BRIEF.md
# Addressed Sample Input Port

This block feeds crisp 8-bit samples into the input registers of an inference engine. A supplier, either a host processor or an external A/D converter, presents a word on a valid/ready stream together with a 3-bit selector. The selector names the input register that receives the word. Words may arrive in any order, because each one carries its own selector. A word that also carries the last flag closes the batch, and the port then starts an elaboration run in the core.

The port helps the supplier in three ways. It drives a handshake pin whose active level is chosen by a configuration input. It shows a next-input number that steps from zero up to a configured highest index and then wraps. It emits a start-conversion pulse of configurable length whenever it is about to take a new sample, so that an external converter can be triggered directly.

Back-pressure rules for the stream:
- A word is taken only in a cycle where `in_valid` and the internal ready are both high.
- Ready is low while a conversion pulse runs, during the start cycle, and for the whole time the core reports busy.
- A supplier may hold `in_valid` high for as long as it likes. Nothing is taken until ready returns.

Top module: `fzin_port`

## Requirements
- R1: While reset is held, the handshake pin is at its inactive level (the inverse of `cfg_rdy_pol`), `next_idx` is 0, and `var_we` and `core_start` are 0.
- R2: A taken word appears on the write port in the following cycle. `var_we` is high for exactly that one cycle, and `var_sel`/`var_data` equal the selector and data that were taken.
- R3: The selector is passed through unchanged, whatever value `next_idx` shows and whatever `cfg_last_idx` is set to.
- R4: A taken word with `in_last` = 1 raises `core_start` for exactly one cycle, the cycle after it was taken (the same cycle as its `var_we`), and sets `next_idx` to 0.
- R5: While the core is busy, or while the port is not ready, `in_valid` has no effect: no `var_we` follows, and the handshake pin stays inactive.
- R6: `rdy_pin` equals the internal ready when `cfg_rdy_pol` = 1, and its inverse when `cfg_rdy_pol` = 0.
- R7: Each taken word with `in_last` = 0 advances `next_idx` by one. The word taken while `next_idx` equals `cfg_last_idx` wraps it to 0.
- R8: `soc_pulse` is high for exactly `cfg_pulse_len` consecutive cycles. The pulse is issued once after reset, once after each non-last word is taken, and once after the core run ends. Ready rises only after the pulse has ended. A length of 0 gives no pulse.
- R9: The core must raise `core_busy` in the cycle after `core_start`. The port treats the run as ended at the first cycle in which `core_busy` is low again, and only then does it prepare for the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rdy_pol | input | 1 | Active level of `rdy_pin` (1 = high) |
| cfg_last_idx | input | SEL_W | Highest input index that `next_idx` reaches |
| cfg_pulse_len | input | PLEN_W | Start-conversion pulse length in cycles |
| in_valid | input | 1 | Stream word valid |
| in_data | input | DATA_W | Sample word |
| in_sel | input | SEL_W | Target input register |
| in_last | input | 1 | Word closes the batch and starts a run |
| rdy_pin | output | 1 | Ready handshake at the configured polarity |
| next_idx | output | SEL_W | Index of the input expected next |
| soc_pulse | output | 1 | Start-conversion pulse for an external converter |
| var_we | output | 1 | Input register write strobe to the core |
| var_sel | output | SEL_W | Input register index being written |
| var_data | output | DATA_W | Input register write data |
| core_start | output | 1 | One-cycle start of an elaboration run |
| core_busy | input | 1 | Core is elaborating |

## Verification
The bench builds the port with its default widths: 8-bit data, a 3-bit selector and a 4-bit pulse-length field. It runs with a highest index of 3 while the selector spans 0 to 7. This makes index wrap-around reachable within four writes, and shows that selectors above the wrap point still pass through unchanged. Further resets switch the handshake to active-low and the pulse length to zero, so that both polarities and the no-pulse case are covered. A behavioural core that holds busy for several cycles gives the bench a window in which to check that writes are ignored and that a fresh pulse follows the run.

// File: rtl/fzin_pkg.sv
package fzin_pkg;
  typedef enum logic [2:0] {
    ST_LOAD  = 3'd0,
    ST_CONV  = 3'd1,
    ST_OPEN  = 3'd2,
    ST_START = 3'd3,
    ST_RUN   = 3'd4
  } fzin_state_e;
endpackage

// File: rtl/fzin_soc_timer.sv
module fzin_soc_timer #(
  parameter int PLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PLEN_W-1:0] len,
  output logic              done,
  output logic              soc
);
  logic [PLEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= len;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
  assign soc  = !done;

  // R8: a running pulse only shortens, one step per cycle
  p_soc_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (soc && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fzin_seq.sv
module fzin_seq
  import fzin_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             core_busy,
  input  logic             tmr_done,
  input  logic [SEL_W-1:0] cfg_last_idx,
  output logic             in_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic             core_start,
  output logic [SEL_W-1:0] next_idx
);
  fzin_state_e state_q, state_d;
  logic [SEL_W-1:0] idx_q;

  assign in_ready   = (state_q == ST_OPEN) && !core_busy;
  assign accept     = in_valid && in_ready;
  assign core_start = (state_q == ST_START);
  assign tmr_load   = (state_q == ST_LOAD)
                    || (accept && !in_last)
                    || ((state_q == ST_RUN) && !core_busy);
  assign next_idx   = idx_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_LOAD:  state_d = ST_CONV;
      ST_CONV:  if (tmr_done) state_d = ST_OPEN;
      ST_OPEN:  if (accept) state_d = in_last ? ST_START : ST_CONV;
      ST_START: state_d = ST_RUN;
      ST_RUN:   if (!core_busy) state_d = ST_CONV;
      default:  state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        if (in_last || idx_q == cfg_last_idx) idx_q <= '0;
        else                                  idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R4: start is a single-cycle pulse
  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R4: closing word rewinds the index
  p_last_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last) |=> (next_idx == '0));
  // R7: index never passes the configured top
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (next_idx <= cfg_last_idx));
endmodule

// File: rtl/fzin_wr_reg.sv
module fzin_wr_reg #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              we,
  output logic [SEL_W-1:0]  sel_out,
  output logic [DATA_W-1:0] data_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we       <= 1'b0;
      sel_out  <= '0;
      data_out <= '0;
    end else begin
      we <= take;
      if (take) begin
        sel_out  <= sel_in;
        data_out <= data_in;
      end
    end
  end
endmodule

// File: rtl/fzin_port.sv
module fzin_port #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int PLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rdy_pol,
  input  logic [SEL_W-1:0]  cfg_last_idx,
  input  logic [PLEN_W-1:0] cfg_pulse_len,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic              in_last,
  output logic              rdy_pin,
  output logic [SEL_W-1:0]  next_idx,
  output logic              soc_pulse,
  output logic              var_we,
  output logic [SEL_W-1:0]  var_sel,
  output logic [DATA_W-1:0] var_data,
  output logic              core_start,
  input  logic              core_busy
);
  logic in_ready, accept, tmr_load, tmr_done;

  fzin_seq #(.SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .core_busy(core_busy), .tmr_done(tmr_done), .cfg_last_idx(cfg_last_idx),
    .in_ready(in_ready), .accept(accept), .tmr_load(tmr_load),
    .core_start(core_start), .next_idx(next_idx)
  );

  fzin_soc_timer #(.PLEN_W(PLEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(cfg_pulse_len),
    .done(tmr_done), .soc(soc_pulse)
  );

  fzin_wr_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .take(accept), .sel_in(in_sel),
    .data_in(in_data), .we(var_we), .sel_out(var_sel), .data_out(var_data)
  );

  assign rdy_pin = cfg_rdy_pol ? in_ready : !in_ready;

  // R2: a taken word shows up on the write port next cycle
  p_write_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (var_we && var_sel == $past(in_sel) && var_data == $past(in_data)));
  // R5: offers during a busy core are dropped
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy |=> !var_we);
  // R8: ready never overlaps the conversion pulse
  p_pulse_before_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soc_pulse |-> !in_ready);
  // R9: busy follows start
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !in_ready);
endmodule

// File: tb/fzin_port_bench.sv
module fzin_port_bench;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  localparam int PLEN_W = 4;
  localparam int BUSY_CYC = 6;
  localparam int NVEC = 8;
  // [14:12] expected next index, [11] last, [10:8] selector, [7:0] data
  localparam logic [14:0] VEC [NVEC] = '{
    {3'd1, 1'b0, 3'd2, 8'h11},
    {3'd2, 1'b0, 3'd0, 8'h22},
    {3'd3, 1'b0, 3'd3, 8'h33},
    {3'd0, 1'b0, 3'd1, 8'h44},
    {3'd1, 1'b0, 3'd5, 8'h55},
    {3'd0, 1'b1, 3'd4, 8'hA6},
    {3'd1, 1'b0, 3'd7, 8'hFF},
    {3'd0, 1'b1, 3'd0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rdy_pol = 1'b1;
  logic [SEL_W-1:0] cfg_last_idx = 3'd3;
  logic [PLEN_W-1:0] cfg_pulse_len = 4'd3;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [SEL_W-1:0] in_sel = '0;
  logic in_last = 1'b0;
  logic rdy_pin, soc_pulse, var_we, core_start, core_busy;
  logic [SEL_W-1:0] next_idx, var_sel;
  logic [DATA_W-1:0] var_data;

  int checks = 0;
  int errors = 0;
  int busy_cnt = 0;
  int soc_run = 0, soc_last_len = 0, soc_pulses = 0;

  always #4 clk = ~clk;

  fzin_port #(.DATA_W(DATA_W), .SEL_W(SEL_W), .PLEN_W(PLEN_W)) u_fzin_port (
    .clk(clk), .rst_n(rst_n), .cfg_rdy_pol(cfg_rdy_pol),
    .cfg_last_idx(cfg_last_idx), .cfg_pulse_len(cfg_pulse_len),
    .in_valid(in_valid), .in_data(in_data), .in_sel(in_sel), .in_last(in_last),
    .rdy_pin(rdy_pin), .next_idx(next_idx), .soc_pulse(soc_pulse),
    .var_we(var_we), .var_sel(var_sel), .var_data(var_data),
    .core_start(core_start), .core_busy(core_busy)
  );

  // behavioural core: busy from the edge that sees start
  always @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else if (core_start) busy_cnt <= BUSY_CYC;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end
  assign core_busy = (busy_cnt != 0);

  // pulse length monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      soc_run = 0; soc_last_len = 0; soc_pulses = 0;
    end else if (soc_pulse) begin
      soc_run++;
    end else if (soc_run != 0) begin
      soc_last_len = soc_run; soc_pulses++; soc_run = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (rdy_pin !== cfg_rdy_pol) @(negedge clk);
  endtask

  task automatic do_reset(input logic pol, input logic [PLEN_W-1:0] len);
    @(negedge clk);
    rst_n = 1'b0; cfg_rdy_pol = pol; cfg_pulse_len = len; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rdy_pin === ~pol, "R1 handshake inactive in reset", rdy_pin, ~pol);
    chk(next_idx === 0, "R1 next_idx in reset", next_idx, 0);
    chk(var_we === 0 && core_start === 0, "R1 write/start idle in reset",
        {var_we, core_start}, 0);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [SEL_W-1:0] s, input logic [DATA_W-1:0] d,
                      input logic l);
    wait_ready();
    in_valid = 1'b1; in_sel = s; in_data = d; in_last = l;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b1, 4'd3);
    wait_ready();
    chk(soc_pulses == 1 && soc_last_len == 3, "R8 pulse after reset",
        soc_last_len, 3);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [14:0] v;
      v = VEC[i];
      send(v[10:8], v[7:0], v[11]);
      chk(var_we === 1'b1, "R2 write strobe", var_we, 1);
      chk(var_sel === v[10:8] && var_data === v[7:0], "R2 R3 write content",
          {var_sel, var_data}, v[10:0]);
      chk(core_start === v[11], "R4 start follows last flag", core_start, v[11]);
      chk(next_idx === v[14:12], "R7 next index", next_idx, v[14:12]);
      @(negedge clk);
      chk(var_we === 1'b0 && core_start === 1'b0, "R2 R4 single cycle strobes",
          {var_we, core_start}, 0);
      wait_ready();
      chk(soc_last_len == 3, "R8 pulse length per sample", soc_last_len, 3);
    end

    // busy window: offers are ignored
    send(3'd6, 8'h5A, 1'b1);
    @(negedge clk);
    chk(core_busy === 1'b1, "R9 core busy after start", core_busy, 1);
    begin
      int p0;
      p0 = soc_pulses;
      in_valid = 1'b1; in_sel = 3'd2; in_data = 8'hC3;
      repeat (2) begin
        @(negedge clk);
        chk(var_we === 1'b0, "R5 no write while busy", var_we, 0);
        chk(rdy_pin === ~cfg_rdy_pol, "R5 handshake inactive while busy",
            rdy_pin, ~cfg_rdy_pol);
      end
      in_valid = 1'b0;
      while (core_busy) @(negedge clk);
      chk(soc_pulses == p0, "R9 no pulse before run ends", soc_pulses, p0);
      wait_ready();
      chk(soc_pulses == p0 + 1, "R9 R8 pulse after run", soc_pulses, p0 + 1);
      chk(next_idx === 0, "R4 index rewound after run", next_idx, 0);
    end

    // active-low handshake
    do_reset(1'b0, 4'd2);
    wait_ready();
    chk(rdy_pin === 1'b0, "R6 active-low ready", rdy_pin, 0);
    chk(soc_last_len == 2, "R8 pulse length 2", soc_last_len, 2);
    send(3'd1, 8'h9C, 1'b0);
    chk(var_we === 1'b1 && var_data === 8'h9C, "R6 R2 write with low polarity",
        var_data, 8'h9C);
    chk(rdy_pin === 1'b1, "R6 inactive high after take", rdy_pin, 1);

    // zero-length pulse
    do_reset(1'b1, 4'd0);
    wait_ready();
    send(3'd0, 8'h01, 1'b0);
    wait_ready();
    chk(soc_pulses == 0, "R8 no pulse when length is zero", soc_pulses, 0);
    chk(next_idx === 1, "R7 index advance", next_idx, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule